// File: doc/BRIEF.md
# Block Lock Protection Controller

This block decides, for every modifying operation aimed at a flash-style array, whether that operation may go ahead. It holds one lock bit for each of 71 blocks and one permanent lock bit. It combines these bits with a write-protect input. A word address arrives with each request. The block maps that address onto an uneven block map: eight small 4K-word blocks at the bottom of the space, then 32K-word main blocks. The small blocks are two boot blocks followed by six parameter blocks.

A request is a valid strobe, an operation code and an address. One cycle later the block answers with a single-cycle grant or deny pulse. Lock-change commands that are granted update the lock state on the same clock edge. Any denial raises a sticky lock-error flag, and the flag stays set until a clear strobe. The lock storage is modelled with ordinary registers that are cleared by reset.

Top module: `blk_lock_ctrl`

## Requirements
- R1: Word addresses 0x000000 to 0x007FFF map to blocks 0 to 7, at 4K words (0x1000) per block. Blocks 0 and 1 are boot blocks and blocks 2 to 7 are parameter blocks. Address 0x008000 and above maps to block 8 + (addr / 0x8000) - 1, at 32K words per block, up to block 70 at 0x1F8000 to 0x1FFFFF.
- R2: After reset, all 71 lock bits and the permanent bit are clear, and grant, deny and lock_err are low.
- R3: Operation codes: 1 word write, 2 block erase, 3 chip erase, 4 set block lock, 5 set permanent lock, 6 clear all block locks. Codes 0 and 7 produce no response. A valid request produces exactly one of grant or deny, as a one-cycle pulse in the cycle after the request.
- R4: A word write or block erase to a locked block is denied while locks are enforced. Locks are enforced when wprot is high or the permanent bit is set.
- R5: When wprot is low and the permanent bit is clear, block lock bits are overridden, so writes and erases to locked blocks are granted.
- R6: A chip erase is denied when locks are enforced and at least one lock bit is set. Otherwise it is granted.
- R7: Set block lock is denied when the permanent bit is set. Otherwise it is granted and sets the lock bit of the addressed block.
- R8: Clear all block locks is denied when the permanent bit is set. Otherwise it is granted and clears every lock bit.
- R9: Set permanent lock is always granted. The permanent bit then stays set until reset, and it enforces the lock bits even with wprot low.
- R10: lock_err is set in the same cycle as any deny pulse and holds until clr_sts is seen. If a deny arrives in the same cycle as the clear, the set wins.
- R11: Setting the lock of one block has no effect on requests aimed at any other block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code (see R3) |
| req_addr | input | 21 | Word address of the request |
| wprot | input | 1 | Write protect; high enforces block locks |
| clr_sts | input | 1 | Clears the lock-error flag |
| grant | output | 1 | One-cycle pulse: request allowed |
| deny | output | 1 | One-cycle pulse: request refused |
| lock_err | output | 1 | Sticky flag raised by any deny |

## Verification
Writes are probed on both sides of every block edge: the last word of one block and the first word of the next, across the boot, parameter and main regions and at the top of the array. These probes separate a correct map from one that is off by a block. They are repeated with wprot high and low, and before and after the permanent bit is set, which tells the override path apart from the two enforcement paths. A full sweep at 4K-word steps, with a few scattered locks and wprot toggling, shows that one lock leaks onto no neighbour and that chip erase depends on the lock vector as a whole. Lock changes attempted after the permanent bit is set, and a deny that coincides with a clear strobe, cover the remaining orderings.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;
  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_WRITE   = 3'd1,
    OP_ERASE   = 3'd2,
    OP_CHIP    = 3'd3,
    OP_SETLK   = 3'd4,
    OP_SETPERM = 3'd5,
    OP_CLRLK   = 3'd6,
    OP_RSVD    = 3'd7
  } lk_op_e;
endpackage

// File: rtl/blk_addr_map.sv
module blk_addr_map #(
  parameter int ADDR_W  = 21,
  parameter int SMALL_W = 12,
  parameter int MAIN_W  = 15,
  parameter int N_SMALL = 8,
  parameter int IDX_W   = 7
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  localparam int HI_W = ADDR_W - MAIN_W;
  localparam int LO_W = MAIN_W - SMALL_W;

  logic [HI_W-1:0] hi;
  logic [LO_W-1:0] lo;

  assign hi = addr[ADDR_W-1:MAIN_W];
  assign lo = addr[MAIN_W-1:SMALL_W];

  // small blocks fill the first main-sized region; main blocks follow
  always_comb begin
    if (hi == '0) idx = IDX_W'(lo);
    else          idx = IDX_W'(hi) + IDX_W'(N_SMALL - 1);
  end
endmodule

// File: rtl/blk_lock_store.sv
module blk_lock_store #(
  parameter int N_BLK = 71,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             clr_all,
  input  logic             perm_set,
  output logic [N_BLK-1:0] lock_q,
  output logic             perm_q
);
  logic [N_BLK-1:0] lock_d;
  logic             perm_d;

  for (genvar g = 0; g < N_BLK; g++) begin : g_bit
    always_comb begin
      if (clr_all)                              lock_d[g] = 1'b0;
      else if (set_en && set_idx == IDX_W'(g))  lock_d[g] = 1'b1;
      else                                      lock_d[g] = lock_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lock_q[g] <= 1'b0;
      else        lock_q[g] <= lock_d[g];
    end
  end

  assign perm_d = perm_q | perm_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) perm_q <= 1'b0;
    else        perm_q <= perm_d;
  end
endmodule

// File: rtl/blk_lock_arb.sv
module blk_lock_arb
  import blk_lock_pkg::*;
(
  input  logic   req_valid,
  input  lk_op_e op,
  input  logic   sel_locked,
  input  logic   any_locked,
  input  logic   perm_q,
  input  logic   wprot,
  output logic   grant_d,
  output logic   deny_d,
  output logic   set_en,
  output logic   clr_all,
  output logic   perm_set
);
  logic enforce;

  assign enforce = wprot | perm_q;

  always_comb begin
    grant_d  = 1'b0;
    deny_d   = 1'b0;
    set_en   = 1'b0;
    clr_all  = 1'b0;
    perm_set = 1'b0;
    if (req_valid) begin
      case (op)
        OP_WRITE, OP_ERASE: begin
          if (sel_locked && enforce) deny_d  = 1'b1;
          else                       grant_d = 1'b1;
        end
        OP_CHIP: begin
          if (any_locked && enforce) deny_d  = 1'b1;
          else                       grant_d = 1'b1;
        end
        OP_SETLK: begin
          if (perm_q) deny_d = 1'b1;
          else begin
            grant_d = 1'b1;
            set_en  = 1'b1;
          end
        end
        OP_CLRLK: begin
          if (perm_q) deny_d = 1'b1;
          else begin
            grant_d = 1'b1;
            clr_all = 1'b1;
          end
        end
        OP_SETPERM: begin
          grant_d  = 1'b1;
          perm_set = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/blk_lock_ctrl.sv
module blk_lock_ctrl
  import blk_lock_pkg::*;
#(
  parameter int ADDR_W  = 21,
  parameter int SMALL_W = 12,
  parameter int MAIN_W  = 15,
  parameter int N_BOOT  = 2,
  parameter int N_PARAM = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              wprot,
  input  logic              clr_sts,
  output logic              grant,
  output logic              deny,
  output logic              lock_err
);
  localparam int N_SMALL = N_BOOT + N_PARAM;
  localparam int N_MAIN  = (1 << (ADDR_W - MAIN_W)) - 1;
  localparam int N_BLK   = N_SMALL + N_MAIN;
  localparam int IDX_W   = $clog2(N_BLK);

  logic [1:0]       rst_sync;
  logic             rst_sync_n;
  logic [IDX_W-1:0] blk_idx;
  logic [N_BLK-1:0] lock_q;
  logic             perm_q;
  logic             sel_locked;
  logic             any_locked;
  logic             grant_d, deny_d, err_d;
  logic             set_en, clr_all, perm_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  blk_addr_map #(
    .ADDR_W (ADDR_W),
    .SMALL_W(SMALL_W),
    .MAIN_W (MAIN_W),
    .N_SMALL(N_SMALL),
    .IDX_W  (IDX_W)
  ) u_map (
    .addr(req_addr),
    .idx (blk_idx)
  );

  blk_lock_store #(
    .N_BLK(N_BLK),
    .IDX_W(IDX_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_en  (set_en),
    .set_idx (blk_idx),
    .clr_all (clr_all),
    .perm_set(perm_set),
    .lock_q  (lock_q),
    .perm_q  (perm_q)
  );

  assign sel_locked = lock_q[blk_idx];
  assign any_locked = |lock_q;

  blk_lock_arb u_arb (
    .req_valid (req_valid),
    .op        (lk_op_e'(req_op)),
    .sel_locked(sel_locked),
    .any_locked(any_locked),
    .perm_q    (perm_q),
    .wprot     (wprot),
    .grant_d   (grant_d),
    .deny_d    (deny_d),
    .set_en    (set_en),
    .clr_all   (clr_all),
    .perm_set  (perm_set)
  );

  always_comb begin
    if (deny_d)       err_d = 1'b1;
    else if (clr_sts) err_d = 1'b0;
    else              err_d = lock_err;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      grant    <= 1'b0;
      deny     <= 1'b0;
      lock_err <= 1'b0;
    end else begin
      grant    <= grant_d;
      deny     <= deny_d;
      lock_err <= err_d;
    end
  end
endmodule

// File: rtl/blk_lock_chk.sv
module blk_lock_chk
  import blk_lock_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [2:0] req_op,
  input logic       wprot,
  input logic       clr_sts,
  input logic       grant,
  input logic       deny,
  input logic       lock_err,
  input logic       perm_q,
  input logic       any_locked
);
  // R3
  one_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grant, deny}));

  // R3
  resp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant || deny) |-> $past(req_valid));

  // R7
  setlk_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_SETLK && perm_q) |=> deny);

  // R9
  perm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    perm_q |=> perm_q);

  // R6
  chip_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_CHIP && (wprot || perm_q) && any_locked) |=> deny);

  // R10
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deny |-> lock_err);

  // R10
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_err && !clr_sts) |=> lock_err);
endmodule

bind blk_lock_ctrl blk_lock_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_valid (req_valid),
  .req_op    (req_op),
  .wprot     (wprot),
  .clr_sts   (clr_sts),
  .grant     (grant),
  .deny      (deny),
  .lock_err  (lock_err),
  .perm_q    (perm_q),
  .any_locked(any_locked)
);

// File: tb/sim_blk_lock_ctrl.sv
module sim_blk_lock_ctrl;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_op;
  logic [20:0] req_addr;
  logic        wprot;
  logic        clr_sts;
  logic        grant, deny, lock_err;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  bit m_lock[71];
  bit m_perm;
  bit e_grant, e_deny, e_err;

  blk_lock_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .wprot(wprot), .clr_sts(clr_sts),
    .grant(grant), .deny(deny), .lock_err(lock_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int blk_of(input int a);
    if (a < 32'h2000)      return a / 32'h1000;
    else if (a < 32'h8000) return 2 + (a - 32'h2000) / 32'h1000;
    else                   return 8 + (a - 32'h8000) / 32'h8000;
  endfunction

  function automatic bit any_lock();
    for (int i = 0; i < 71; i++) if (m_lock[i]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (grant !== e_grant || deny !== e_deny || lock_err !== e_err) begin
      errors++;
      $display("FAIL %s: got grant=%b deny=%b err=%b, expected grant=%b deny=%b err=%b",
               tag, grant, deny, lock_err, e_grant, e_deny, e_err);
    end
  endtask

  task automatic step(input bit v, input int op, input int a, input bit w,
                      input bit c, input string tag);
    int  b;
    bit  enf;
    req_valid = v; req_op = op[2:0]; req_addr = a[20:0]; wprot = w; clr_sts = c;
    b = blk_of(a);
    enf = w || m_perm;
    e_grant = 0; e_deny = 0;
    if (v) begin
      case (op)
        1, 2: if (m_lock[b] && enf) e_deny = 1; else e_grant = 1;
        3:    if (any_lock() && enf) e_deny = 1; else e_grant = 1;
        4:    if (m_perm) e_deny = 1; else begin e_grant = 1; m_lock[b] = 1; end
        5:    begin e_grant = 1; m_perm = 1; end
        6:    if (m_perm) e_deny = 1;
              else begin e_grant = 1; for (int i = 0; i < 71; i++) m_lock[i] = 0; end
        default: ;
      endcase
    end
    if (e_deny) e_err = 1;
    else if (c) e_err = 0;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 1, 0, tag);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got no finish, expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 71; i++) m_lock[i] = 0;
    m_perm = 0; e_grant = 0; e_deny = 0; e_err = 0;
    rst_n = 0; req_valid = 0; req_op = 0; req_addr = 0; wprot = 1; clr_sts = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2 reset state
    repeat (3) idle("R2");
    step(1, 1, 'h000000, 1, 0, "R2");
    step(1, 2, 'h1FFFFF, 1, 0, "R2");
    step(1, 3, 'h000000, 1, 0, "R2");

    // R1 edges of boot, parameter and main regions
    step(1, 4, 'h001000, 1, 0, "R7");
    step(1, 1, 'h000FFF, 1, 0, "R1");
    step(1, 1, 'h001000, 1, 0, "R1");
    step(1, 1, 'h001FFF, 1, 0, "R1");
    step(1, 1, 'h002000, 1, 0, "R1");
    step(1, 4, 'h007000, 1, 0, "R7");
    step(1, 1, 'h006FFF, 1, 0, "R1");
    step(1, 2, 'h007FFF, 1, 0, "R4");
    step(1, 1, 'h008000, 1, 0, "R1");
    step(1, 4, 'h008000, 1, 0, "R7");
    step(1, 1, 'h00FFFF, 1, 0, "R1");
    step(1, 1, 'h010000, 1, 0, "R11");
    step(1, 4, 'h1F8000, 1, 0, "R7");
    step(1, 1, 'h1FFFFF, 1, 0, "R1");
    step(1, 1, 'h1F7FFF, 1, 0, "R11");

    // R5 override with wprot low
    step(1, 1, 'h001000, 0, 0, "R5");
    step(1, 2, 'h008000, 0, 0, "R5");

    // R6 chip erase
    step(1, 3, 'h000000, 1, 0, "R6");
    step(1, 3, 'h000000, 0, 0, "R6");

    // R10 sticky error, clear, and deny coinciding with clear
    idle("R10");
    step(0, 0, 0, 1, 1, "R10");
    idle("R10");
    step(1, 2, 'h001000, 1, 1, "R10");
    idle("R10");
    step(0, 0, 0, 1, 1, "R10");

    // R3 reserved codes give no response
    step(1, 0, 'h001000, 1, 0, "R3");
    step(1, 7, 'h001000, 1, 0, "R3");
    idle("R3");

    // R8 clear all without permanent lock
    step(1, 6, 'h000000, 1, 0, "R8");
    step(1, 1, 'h001000, 1, 0, "R8");
    step(1, 1, 'h1FFFFF, 1, 0, "R8");
    step(1, 3, 'h000000, 1, 0, "R8");

    // R11 sweep with scattered locks
    step(1, 4, 'h003000, 1, 0, "R11");
    step(1, 4, 'h0A0000, 1, 0, "R11");
    for (int a = 0; a < 'h200000; a += 'h1000)
      step(1, (a[12] ? 2 : 1), a + 'h0FFF, a[13], 0, "R11");
    step(1, 3, 'h000000, 1, 0, "R6");

    // R9 permanent lock
    step(0, 0, 0, 1, 1, "R10");
    step(1, 5, 'h000000, 0, 0, "R9");
    step(1, 1, 'h003000, 0, 0, "R9");
    step(1, 1, 'h004000, 0, 0, "R9");
    step(1, 3, 'h000000, 0, 0, "R9");
    step(1, 4, 'h010000, 0, 0, "R7");
    step(1, 1, 'h010000, 1, 0, "R7");
    step(1, 6, 'h000000, 1, 0, "R8");
    step(1, 2, 'h0A0000, 0, 0, "R8");
    step(1, 5, 'h000000, 1, 0, "R9");
    repeat (3) idle("R9");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule